// File: doc/BRIEF.md
# Complementary gate pair stage with dead time

This block drives one phase leg of a bridge. From a raw compare result it forms a reference level under control of a mode select (follow the compare, hold high, hold low, or freeze the last value). It then turns that reference into a high-side and a low-side gate signal. When both sides are enabled, a programmable dead time is inserted, so that each side turns on only after the other has been off for that many clock cycles. When just one side is enabled, that side follows the reference (or its inverse) with no gap.

A global output enable overrides everything and puts both pins at their idle level. A side whose own enable is clear is driven to its inactive level. The mode, the enables, the global enable and the compare input are all sampled on the clock. The dead-time value resets to 10 cycles and can be rewritten through a write strobe. Polarity and idle levels are parameters; the defaults are active-high outputs that idle high.

Top module: `gate_pair_stage`

## Requirements
- R1: While reset is held and until the global enable is sampled high, both gate pins sit at the idle level (1 for both by default), and the dead time is 10 cycles.
- R2: The reference is updated at each clock edge from the mode sampled there. Mode code 2'b01 follows `cmp_i`, 2'b11 holds the reference at 1, and 2'b10 holds it at 0.
- R3: Mode code 2'b00 (frozen) keeps the reference at its previous value whatever `cmp_i` does.
- R4: With both sides enabled, the high side rises exactly DT clock edges after the edge that made the reference 1. The low side rises exactly DT edges after the edge that made it 0. The two sides are never active together.
- R5: A reference pulse shorter than the dead time produces no pulse on the side it would have turned on.
- R6: With only one side enabled, that side follows the reference (the high side) or its inverse (the low side) with no delay, and the disabled side is held inactive.
- R7: With the global enable high and neither side enabled, both pins are inactive (0 by default).
- R8: When the global enable is sampled low, both pins go to their idle levels at that edge, whatever the mode, the enables or the compare input.
- R9: A change of the mode code or of either side enable restarts the dead-time count, even when the reference does not change and even in the middle of a running count.
- R10: A pulse on `dt_wr_i` loads `dt_val_i` as the new dead time, which then applies from the next reference edge. A dead time of 0 gives no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 1 | Raw PWM compare result |
| mode_i | input | 2 | Reference mode: 00 frozen, 01 PWM, 10 forced low, 11 forced high |
| en_hi_i | input | 1 | High-side (main) output enable |
| en_lo_i | input | 1 | Low-side (complementary) output enable |
| moe_i | input | 1 | Global output enable |
| dt_wr_i | input | 1 | Dead-time write strobe |
| dt_val_i | input | DT_W | Dead-time value in clock cycles |
| gate_hi_o | output | 1 | High-side gate |
| gate_lo_o | output | 1 | Low-side gate |

## Verification
The hardest cases to reach are a reference pulse that ends inside the dead time and a mode or enable change that lands while a count is already running. Both need the inputs to move within a few cycles of an edge. Directed sequences create a five-cycle pulse against a ten-cycle dead time, and a mode change that leaves the reference unchanged. A long random phase with short programmed dead times then makes edges, configuration changes and dead-time writes collide in many orders. A behavioural model checks every cycle of it.

// File: rtl/gps_pkg.sv
package gps_pkg;
   typedef enum logic [1:0] {
      MD_FROZEN = 2'b00,
      MD_PWM    = 2'b01,
      MD_LOW    = 2'b10,
      MD_HIGH   = 2'b11
   } ref_mode_e;
endpackage

// File: rtl/gps_ref_sel.sv
// Samples the mode, enables and global enable; forms the reference level and
// flags any reference edge or configuration change for the dead-time counter.
module gps_ref_sel
   import gps_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmp_i,
   input  logic [1:0] mode_i,
   input  logic       en_hi_i,
   input  logic       en_lo_i,
   input  logic       moe_i,
   output logic       ref_o,
   output logic       en_hi_o,
   output logic       en_lo_o,
   output logic       moe_o,
   output logic       restart_o
);
   localparam int CFG_W = 4;

   logic [CFG_W-1:0] cfg_q, cfg_d;
   logic             ref_q, ref_d, moe_q;

   always_comb begin
      case (ref_mode_e'(mode_i))
         MD_PWM:  ref_d = cmp_i;
         MD_HIGH: ref_d = 1'b1;
         MD_LOW:  ref_d = 1'b0;
         default: ref_d = ref_q;
      endcase
   end

   assign cfg_d     = {mode_i, en_hi_i, en_lo_i};
   assign restart_o = (ref_d != ref_q) || (cfg_d != cfg_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= 1'b0;
         cfg_q <= '0;
         moe_q <= 1'b0;
      end else begin
         ref_q <= ref_d;
         cfg_q <= cfg_d;
         moe_q <= moe_i;
      end
   end

   assign ref_o   = ref_q;
   assign en_hi_o = cfg_q[1];
   assign en_lo_o = cfg_q[0];
   assign moe_o   = moe_q;
endmodule

// File: rtl/gps_deadtime.sv
// Holds the programmable dead time and counts it down after each restart.
module gps_deadtime #(
   parameter int DT_W     = 8,
   parameter int DT_RESET = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dt_wr_i,
   input  logic [DT_W-1:0] dt_val_i,
   input  logic            restart_i,
   output logic            busy_o,
   output logic [DT_W-1:0] dt_o
);
   localparam logic [DT_W-1:0] DT_INIT = DT_W'(DT_RESET);

   logic [DT_W-1:0] dt_q, cnt_q;

   assign busy_o = (cnt_q != '0);
   assign dt_o   = dt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dt_q  <= DT_INIT;
         cnt_q <= '0;
      end else begin
         if (dt_wr_i)
            dt_q <= dt_val_i;
         if (restart_i)
            cnt_q <= dt_q;
         else if (busy_o)
            cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/gps_out_map.sv
// Maps reference, dead-zone flag and enables onto the two pins.
// Side 0 is the high side (reference), side 1 the low side (inverse).
module gps_out_map #(
   parameter bit IDLE_HI = 1'b1,
   parameter bit IDLE_LO = 1'b1,
   parameter bit POL_HI  = 1'b0,
   parameter bit POL_LO  = 1'b0
) (
   input  logic ref_i,
   input  logic busy_i,
   input  logic en_hi_i,
   input  logic en_lo_i,
   input  logic moe_i,
   output logic gate_hi_o,
   output logic gate_lo_o
);
   localparam int         SIDES  = 2;
   localparam bit [1:0]   IDLE_V = {IDLE_LO, IDLE_HI};
   localparam bit [1:0]   POL_V  = {POL_LO, POL_HI};

   logic [SIDES-1:0] en_v, pin_v;

   assign en_v = {en_lo_i, en_hi_i};

   for (genvar s = 0; s < SIDES; s++) begin : g_side
      logic phase, act;
      assign phase = (s == 0) ? ref_i : ~ref_i;
      always_comb begin
         if (!en_v[s])
            act = 1'b0;
         else if (en_v[SIDES-1-s])
            act = phase & ~busy_i;
         else
            act = phase;
         pin_v[s] = moe_i ? (act ^ POL_V[s]) : IDLE_V[s];
      end
   end

   assign gate_hi_o = pin_v[0];
   assign gate_lo_o = pin_v[1];
endmodule

// File: rtl/gate_pair_stage.sv
module gate_pair_stage #(
   parameter int DT_W     = 8,
   parameter int DT_RESET = 10,
   parameter bit IDLE_HI  = 1'b1,
   parameter bit IDLE_LO  = 1'b1,
   parameter bit POL_HI   = 1'b0,
   parameter bit POL_LO   = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmp_i,
   input  logic [1:0]      mode_i,
   input  logic            en_hi_i,
   input  logic            en_lo_i,
   input  logic            moe_i,
   input  logic            dt_wr_i,
   input  logic [DT_W-1:0] dt_val_i,
   output logic            gate_hi_o,
   output logic            gate_lo_o
);
   localparam longint DT_MAX = (64'd1 << DT_W) - 1;

   if (DT_W < 1 || DT_W > 16) begin : g_bad_w
      $error("gate_pair_stage: DT_W must lie in 1..16");
   end
   if (DT_RESET < 0 || DT_RESET > DT_MAX) begin : g_bad_rst
      $error("gate_pair_stage: DT_RESET does not fit in DT_W bits");
   end

   logic            ref_w, en_hi_w, en_lo_w, moe_w, restart_w, busy_w;
   logic [DT_W-1:0] dt_w;

   gps_ref_sel u_ref (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmp_i     (cmp_i),
      .mode_i    (mode_i),
      .en_hi_i   (en_hi_i),
      .en_lo_i   (en_lo_i),
      .moe_i     (moe_i),
      .ref_o     (ref_w),
      .en_hi_o   (en_hi_w),
      .en_lo_o   (en_lo_w),
      .moe_o     (moe_w),
      .restart_o (restart_w)
   );

   gps_deadtime #(.DT_W(DT_W), .DT_RESET(DT_RESET)) u_dt (
      .clk       (clk),
      .rst_n     (rst_n),
      .dt_wr_i   (dt_wr_i),
      .dt_val_i  (dt_val_i),
      .restart_i (restart_w),
      .busy_o    (busy_w),
      .dt_o      (dt_w)
   );

   gps_out_map #(
      .IDLE_HI(IDLE_HI), .IDLE_LO(IDLE_LO),
      .POL_HI(POL_HI),   .POL_LO(POL_LO)
   ) u_map (
      .ref_i     (ref_w),
      .busy_i    (busy_w),
      .en_hi_i   (en_hi_w),
      .en_lo_i   (en_lo_w),
      .moe_i     (moe_w),
      .gate_hi_o (gate_hi_o),
      .gate_lo_o (gate_lo_o)
   );
endmodule

// File: rtl/gps_chk.sv
module gps_chk #(
   parameter int DT_W    = 8,
   parameter bit IDLE_HI = 1'b1,
   parameter bit IDLE_LO = 1'b1,
   parameter bit POL_HI  = 1'b0,
   parameter bit POL_LO  = 1'b0
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      mode_i,
   input logic            dt_wr_i,
   input logic [DT_W-1:0] dt_val_i,
   input logic            ref_q,
   input logic            busy,
   input logic            en_hi,
   input logic            en_lo,
   input logic            moe,
   input logic [DT_W-1:0] dt_q,
   input logic            gate_hi_o,
   input logic            gate_lo_o
);
   logic act_hi, act_lo;
   assign act_hi = gate_hi_o ^ POL_HI;
   assign act_lo = gate_lo_o ^ POL_LO;

   // R8
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !moe |-> (gate_hi_o == IDLE_HI && gate_lo_o == IDLE_LO));

   // R4
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (moe && en_hi && en_lo) |-> !(act_hi && act_lo));

   // R9
   dead_zone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (moe && en_hi && en_lo && busy) |-> (!act_hi && !act_lo));

   // R3
   frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b00) |=> (ref_q == $past(ref_q)));

   // R2
   force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b11) |=> ref_q);

   // R2
   force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b10) |=> !ref_q);

   // R10
   dt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dt_wr_i |=> (dt_q == $past(dt_val_i)));
endmodule

bind gate_pair_stage gps_chk #(
   .DT_W(DT_W), .IDLE_HI(IDLE_HI), .IDLE_LO(IDLE_LO),
   .POL_HI(POL_HI), .POL_LO(POL_LO)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_i    (mode_i),
   .dt_wr_i   (dt_wr_i),
   .dt_val_i  (dt_val_i),
   .ref_q     (ref_w),
   .busy      (busy_w),
   .en_hi     (en_hi_w),
   .en_lo     (en_lo_w),
   .moe       (moe_w),
   .dt_q      (dt_w),
   .gate_hi_o (gate_hi_o),
   .gate_lo_o (gate_lo_o)
);

// File: tb/gate_pair_stage_bench.sv
module gate_pair_stage_bench;
   localparam int DT_W = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cmp_i = 1'b0;
   logic [1:0]      mode_i = 2'b00;
   logic            en_hi_i = 1'b0;
   logic            en_lo_i = 1'b0;
   logic            moe_i = 1'b0;
   logic            dt_wr_i = 1'b0;
   logic [DT_W-1:0] dt_val_i = '0;
   logic            gate_hi_o, gate_lo_o;

   int    n_chk = 0, n_bad = 0;
   bit    done = 1'b0;
   bit    cmp_on = 1'b0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   gate_pair_stage u_gate_pair_stage (
      .clk(clk), .rst_n(rst_n), .cmp_i(cmp_i), .mode_i(mode_i),
      .en_hi_i(en_hi_i), .en_lo_i(en_lo_i), .moe_i(moe_i),
      .dt_wr_i(dt_wr_i), .dt_val_i(dt_val_i),
      .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o)
   );

   // behavioural reference model
   int m_ref, m_cnt, m_cfg, m_moe, m_dt;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ref = 0; m_cnt = 0; m_cfg = 0; m_moe = 0; m_dt = 10;
      end else begin
         int nref, ncfg;
         case (mode_i)
            2'b01:   nref = cmp_i;
            2'b11:   nref = 1;
            2'b10:   nref = 0;
            default: nref = m_ref;
         endcase
         ncfg = mode_i * 4 + en_hi_i * 2 + en_lo_i;
         if (nref != m_ref || ncfg != m_cfg) m_cnt = m_dt;
         else if (m_cnt > 0) m_cnt = m_cnt - 1;
         m_ref = nref;
         m_cfg = ncfg;
         m_moe = moe_i;
         if (dt_wr_i) m_dt = dt_val_i;
      end
   end

   task automatic chk(string req, logic got, logic exp, string what);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         logic eh, el, xh, xl;
         eh = m_cfg[1]; el = m_cfg[0];
         if (m_moe == 0) begin
            xh = 1'b1; xl = 1'b1;
         end else begin
            xh = eh ? (el ? (m_ref == 1 && m_cnt == 0) : (m_ref == 1)) : 1'b0;
            xl = el ? (eh ? (m_ref == 0 && m_cnt == 0) : (m_ref == 0)) : 1'b0;
         end
         chk(cur_req, gate_hi_o, xh, "model gate_hi");
         chk(cur_req, gate_lo_o, xl, "model gate_lo");
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   // counts sampled negedges until the chosen pin reads 1
   task automatic wait_on(bit hi_side, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (((hi_side ? gate_hi_o : gate_lo_o) !== 1'b1) && n < 60);
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int n;
      bit seen;
      step(3);
      cur_req = "R1";
      chk("R1", gate_hi_o, 1'b1, "reset idle hi");
      chk("R1", gate_lo_o, 1'b1, "reset idle lo");
      rst_n = 1'b1; cmp_on = 1'b1;
      mode_i = 2'b01; en_hi_i = 1; en_lo_i = 1; cmp_i = 1;
      step(4);
      chk("R8", gate_hi_o, 1'b1, "moe low hi idle");
      chk("R8", gate_lo_o, 1'b1, "moe low lo idle");

      // both sides enabled, reset dead time of 10
      cur_req = "R4"; cmp_i = 0; moe_i = 1;
      step(15);
      cmp_i = 1; wait_on(1, n);
      chk("R4", n == 11, 1'b1, "hi delay of 10 (R1 reset dead time)");
      step(3);
      cmp_i = 0; wait_on(0, n);
      chk("R4", n == 11, 1'b1, "lo delay of 10");

      // short pulse
      cur_req = "R5"; step(3);
      cmp_i = 1; step(5); cmp_i = 0;
      seen = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (gate_hi_o) seen = 1;
      end
      chk("R5", seen, 1'b0, "no high pulse from 5-cycle reference");

      // config change without reference change
      cur_req = "R9"; cmp_i = 1; step(15);
      mode_i = 2'b11; wait_on(1, n);
      chk("R9", n == 11, 1'b1, "mode change restarts dead time");

      // single side enabled, forced modes
      cur_req = "R6"; en_lo_i = 0; mode_i = 2'b10; step(2);
      chk("R2", gate_hi_o, 1'b0, "forced low, hi only");
      mode_i = 2'b11; step(1);
      chk("R6", gate_hi_o, 1'b1, "hi only, no delay");
      chk("R6", gate_lo_o, 1'b0, "lo disabled inactive");

      // frozen
      cur_req = "R3"; mode_i = 2'b00; cmp_i = 0; step(3);
      chk("R3", gate_hi_o, 1'b1, "frozen keeps 1");
      cmp_i = 1; step(1); cmp_i = 0; step(2);
      chk("R3", gate_hi_o, 1'b1, "frozen ignores compare");

      cur_req = "R6"; mode_i = 2'b01; en_hi_i = 0; en_lo_i = 1; cmp_i = 0; step(1);
      chk("R6", gate_lo_o, 1'b1, "lo only follows inverse");
      chk("R6", gate_hi_o, 1'b0, "hi disabled inactive");

      cur_req = "R7"; en_lo_i = 0; step(2);
      chk("R7", gate_hi_o, 1'b0, "neither enabled hi");
      chk("R7", gate_lo_o, 1'b0, "neither enabled lo");

      // programmed dead time
      cur_req = "R10"; en_hi_i = 1; en_lo_i = 1;
      dt_val_i = 8'd3; dt_wr_i = 1; step(1); dt_wr_i = 0; step(15);
      cmp_i = 1; wait_on(1, n);
      chk("R10", n == 4, 1'b1, "dead time 3");
      dt_val_i = 8'd0; dt_wr_i = 1; step(1); dt_wr_i = 0; step(5);
      cmp_i = 0; wait_on(0, n);
      chk("R10", n == 1, 1'b1, "dead time 0 no gap");

      cur_req = "R8"; moe_i = 0; step(1);
      chk("R8", gate_hi_o & gate_lo_o, 1'b1, "moe drop to idle");

      // random mix against the model
      cur_req = "R4 R9 mix";
      for (int i = 0; i < 3000; i++) begin
         cmp_i   = ($urandom % 4) != 0 ? cmp_i : ~cmp_i;
         if ($urandom % 16 == 0) mode_i = 2'($urandom);
         if ($urandom % 20 == 0) en_hi_i = ~en_hi_i;
         if ($urandom % 20 == 0) en_lo_i = ~en_lo_i;
         if ($urandom % 40 == 0) moe_i = ~moe_i;
         dt_wr_i = ($urandom % 50 == 0);
         dt_val_i = DT_W'($urandom % 6);
         step(1);
      end
      dt_wr_i = 0;
      step(2);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule